// File: doc/BRIEF.md
# Windowed Event Counter Bank

A bank of four 32-bit counters placed beside a memory controller to measure its activity. Counter 0 always counts clock cycles and serves as the measurement window; counters 1 to 3 each count the event chosen by their own selection register. The selection picks either one of the generic event pulses or one of two filtered traffic events: read or write transfers whose ID matches a shared ID/mask filter.

Software presets counter 0 so that it reaches its limit after the desired number of cycles, sets the enable bit, and waits for the interrupt. When counter 0 steps past all ones the whole bank freezes and the interrupt rises. Counters 1 to 3 wrap silently. Writing 1 to the status bit releases the freeze and drops the interrupt.

Top module: `perf_window_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While the enable bit (control bit 0) is 1 and the bank is not frozen, counter 0 increases by one on every clock edge, whatever its selection register holds.
- R3: A counter among 1 to 3 whose selection code k is below NUM_EVT increases by one on each enabled edge where `evt_in[k]` is 1.
- R4: Selection code 0x41 counts enabled edges with `rd_valid` high and `(rd_id & mask) == (match & mask)`; code 0x42 does the same with `wr_valid` and `wr_id`. The filter register holds match in bits [ID_W-1:0] and mask in bits [16+ID_W-1:16]; a mask bit of 1 means the ID bit is compared.
- R5: Any other selection code (NUM_EVT up to 0x40, 0x43 and above) makes that counter hold its value.
- R6: Counters 1 to 3 go from 0xFFFFFFFF to 0 and keep counting, with no interrupt.
- R7: On the edge where counter 0 goes from 0xFFFFFFFF to 0, the bank freezes and `irq` and status bit 0 become 1; after that edge no counter changes.
- R8: Writing 1 to status bit 0 clears the freeze and `irq`; counting resumes on the next edge if enabled. Writing 0 to it has no effect.
- R9: A write to a counter register loads the written value on that edge, taking priority over its increment.
- R10: With the enable bit 0 no counter changes.
- R11: Register map on `reg_addr`: 0 control, 1 status, 2 filter, 4+n selection of counter n (8 bits), 8+n value of counter n; other addresses read 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NUM_EVT | Generic event pulses, one per cycle per bit |
| rd_valid | input | 1 | A read transfer occurs this cycle |
| rd_id | input | ID_W | ID of that read |
| wr_valid | input | 1 | A write transfer occurs this cycle |
| wr_id | input | ID_W | ID of that write |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Window-expired interrupt, level |

## Verification
The assertions take for granted that event and traffic inputs are single-cycle levels sampled on each edge and that register writes last exactly one cycle with stable address and data. They also assume no write to counter 0 lands on the edge where it would expire, since a load then overrides the freeze. The stimulus drives every input half a cycle away from the sampling edge, holds each write for one edge only, and presets counter 0 well clear of its limit except in the one sequence that aims at expiry.

// File: rtl/perf_window_bank.sv
module perf_window_bank #(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16,
  parameter int ID_W    = 8,
  parameter int SEL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               rd_valid,
  input  logic [ID_W-1:0]    rd_id,
  input  logic               wr_valid,
  input  logic [ID_W-1:0]    wr_id,
  input  logic               reg_wen,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int EIW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_FILT = 4'd2;
  localparam logic [3:0] A_SEL  = 4'd4;
  localparam logic [3:0] A_CNT  = 4'd8;
  localparam logic [SEL_W-1:0] CODE_RD = SEL_W'('h41);
  localparam logic [SEL_W-1:0] CODE_WR = SEL_W'('h42);

  logic                          enable, frozen;
  logic [ID_W-1:0]               f_match, f_mask;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            hit, cnt_wr;
  logic                          run, rd_ok, wr_ok, expire, stat_clr;

  assign run      = enable & ~frozen;
  assign rd_ok    = rd_valid & ((rd_id & f_mask) == (f_match & f_mask));
  assign wr_ok    = wr_valid & ((wr_id & f_mask) == (f_match & f_mask));
  assign expire   = run & (&cnt[0]) & ~cnt_wr[0];
  assign stat_clr = reg_wen & (reg_addr == A_STAT) & reg_wdata[0];
  assign irq      = frozen;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_wr[g] = reg_wen & (reg_addr == A_CNT + 4'(g));
    if (g == 0) begin : g_time
      assign hit[g] = 1'b1;
    end else begin : g_evt
      always_comb begin
        if (sel[g] == CODE_RD)              hit[g] = rd_ok;
        else if (sel[g] == CODE_WR)         hit[g] = wr_ok;
        else if (sel[g] < SEL_W'(NUM_EVT))  hit[g] = evt_in[EIW'(sel[g])];
        else                                hit[g] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[g] <= '0;
        sel[g] <= '0;
      end else begin
        if (cnt_wr[g])         cnt[g] <= reg_wdata[CNT_W-1:0];
        else if (run & hit[g]) cnt[g] <= cnt[g] + 1'b1;
        if (reg_wen && reg_addr == A_SEL + 4'(g)) sel[g] <= reg_wdata[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      frozen  <= 1'b0;
      f_match <= '0;
      f_mask  <= '0;
    end else begin
      if (reg_wen && reg_addr == A_CTRL) enable <= reg_wdata[0];
      if (reg_wen && reg_addr == A_FILT) begin
        f_match <= reg_wdata[ID_W-1:0];
        f_mask  <= reg_wdata[16+ID_W-1:16];
      end
      if (expire)        frozen <= 1'b1;
      else if (stat_clr) frozen <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[0] = enable;
      A_STAT: reg_rdata[0] = frozen;
      A_FILT: begin
        reg_rdata[ID_W-1:0]     = f_match;
        reg_rdata[16+ID_W-1:16] = f_mask;
      end
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (reg_addr == A_SEL + 4'(i)) reg_rdata[SEL_W-1:0] = sel[i];
          if (reg_addr == A_CNT + 4'(i)) reg_rdata[CNT_W-1:0] = cnt[i];
        end
      end
    endcase
  end

  // R2: the window counter steps by one per enabled, unfrozen edge
  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr[0] && !(&cnt[0])) |=> cnt[0] == $past(cnt[0]) + 1'b1);

  // R7: reaching the limit freezes the bank and raises the interrupt
  p_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr[0] && (&cnt[0])) |=> (irq && cnt[0] == '0));

  // R7: while frozen nothing moves unless software loads a counter
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && cnt_wr == '0) |=> $stable(cnt));

  // R6: the interrupt rises only on window expiry
  p_no_spurious_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(run && (&cnt[0]))) |=> !irq);

  // R8: a one written to status releases the bank
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !expire) |=> !irq);

  // R9: a counter write lands on its edge
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr[1] |=> cnt[1] == $past(reg_wdata[CNT_W-1:0]));

  // R10: disabled bank holds all counts
  p_disabled_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && cnt_wr == '0) |=> $stable(cnt));
endmodule

// File: tb/perf_window_bank_test.sv
`timescale 1ns/1ps
module perf_window_bank_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] evt_in = '0;
  logic        rd_valid = 0, wr_valid = 0;
  logic [7:0]  rd_id = '0, wr_id = '0;
  logic        reg_wen = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 0;

  perf_window_bank uut (.clk, .rst_n, .evt_in, .rd_valid, .rd_id, .wr_valid, .wr_id,
                        .reg_wen, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wen = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic quiet();
    evt_in = '0; rd_valid = 0; wr_valid = 0;
  endtask

  initial begin
    logic [31:0] v;
    int e1, e2, e3;
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    int e1, e2, e3;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R11: reset values across the whole map
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R11: readback of filter and selections
    wr(4'd2, 32'h00F0005A);
    rd(4'd2, v); chk("R11 filter readback", v, 32'h00F0005A);
    wr(4'd5, 32'h3); wr(4'd6, 32'h41); wr(4'd7, 32'h42);
    rd(4'd6, v); chk("R11 select readback", v, 32'h41);
    rd(4'd3, v); chk("R11 unmapped", v, 32'h0);

    // R2 R3 R4: sweep of mixed traffic
    e1 = 0; e2 = 0; e3 = 0;
    wr(4'd0, 32'h1);
    for (int i = 0; i < 512; i++) begin
      evt_in = 16'(i * 37); rd_valid = i[0]; rd_id = i[8:1];
      wr_valid = i[1] ^ i[4]; wr_id = 8'(i * 5);
      if (evt_in[3]) e1++;
      if (rd_valid && ((rd_id & 8'hF0) == 8'h50)) e2++;
      if (wr_valid && ((wr_id & 8'hF0) == 8'h50)) e3++;
      step(1);
    end
    quiet();
    wr(4'd0, 32'h0);
    rd(4'd8, v);  chk("R2 cycle count", v, 32'd513);
    rd(4'd9, v);  chk("R3 event bit 3", v, 32'(e1));
    rd(4'd10, v); chk("R4 filtered reads", v, 32'(e2));
    rd(4'd11, v); chk("R4 filtered writes", v, 32'(e3));

    // R10: disabled bank holds
    evt_in = '1; rd_valid = 1; rd_id = 8'h5A; wr_valid = 1; wr_id = 8'h5A;
    step(6);
    rd(4'd8, v); chk("R10 counter0 held", v, 32'd513);
    rd(4'd10, v); chk("R10 counter2 held", v, 32'(e2));

    // R5: unsupported codes count nothing while every source is active
    wr(4'd9, 0); wr(4'd10, 0); wr(4'd11, 0);
    wr(4'd5, 32'h10); wr(4'd6, 32'h40); wr(4'd7, 32'h43);
    wr(4'd0, 32'h1); step(8); wr(4'd0, 32'h0);
    rd(4'd9, v);  chk("R5 code 0x10", v, 0);
    rd(4'd10, v); chk("R5 code 0x40", v, 0);
    rd(4'd11, v); chk("R5 code 0x43", v, 0);
    quiet();

    // R3: every generic event line selected in turn
    for (int k = 0; k < 16; k++) begin
      wr(4'd9, 0); wr(4'd5, 32'(k)); wr(4'd0, 1);
      for (int c = 0; c < 20; c++) begin
        evt_in = (c % 3 == 0) ? 16'hFFFF : ~(16'h1 << k);
        step(1);
      end
      quiet(); wr(4'd0, 0);
      rd(4'd9, v); chk($sformatf("R3 line %0d", k), v, 32'd7);
    end

    // R6: silent wrap of counter 1
    wr(4'd8, 0); wr(4'd5, 0); wr(4'd9, 32'hFFFFFFFE); wr(4'd0, 1);
    evt_in = 16'h1; step(3); quiet(); wr(4'd0, 0);
    rd(4'd9, v); chk("R6 wrapped value", v, 32'h1);
    chk("R6 no irq", {31'b0, irq}, 0);

    // R9: load takes priority over increment
    wr(4'd0, 1); evt_in = 16'h1;
    wr(4'd9, 32'h100); step(2);
    rd(4'd9, v); chk("R9 load then count", v, 32'h102);
    quiet(); wr(4'd0, 0);

    // R7: window expiry freezes bank
    wr(4'd9, 32'h20); wr(4'd8, 32'hFFFFFFFD);
    evt_in = 16'h1;
    wr(4'd0, 1);
    step(2);
    chk("R7 irq before limit", {31'b0, irq}, 0);
    step(1);
    chk("R7 irq on expiry", {31'b0, irq}, 1);
    step(10);
    rd(4'd8, v); chk("R7 counter0 frozen", v, 0);
    rd(4'd9, v); chk("R7 counter1 frozen", v, 32'h23);
    rd(4'd1, v); chk("R7 status set", v, 1);

    // R8: writing zero leaves the freeze, writing one releases it
    wr(4'd1, 0); step(3);
    rd(4'd8, v); chk("R8 zero write ignored", v, 0);
    chk("R8 irq kept", {31'b0, irq}, 1);
    wr(4'd1, 1);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    step(5);
    rd(4'd8, v); chk("R8 counting resumed", v, 32'd5);
    rd(4'd9, v); chk("R8 counter1 resumed", v, 32'h28);
    quiet(); wr(4'd0, 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule